// File: doc/BRIEF.md
# Serial Control and Result Port for a 12-bit Converter

This block is the digital side of a 12-bit converter's serial port. A frame starts when the active-low select goes low and ends when it goes high. During a frame the block takes an 8-bit control word in on the data input, one bit per rising serial-clock edge. On the same serial clock it sends the previous conversion result out on the data output. The control word carries, starting with the first bit received: a 4-bit channel address, a 2-bit output length code, a bit-order flag and a number-format flag.

The fields do not all take effect at the same point. The length code governs the frame that carries it. The order flag governs the following frame. The format flag governs the conversion that this frame starts. When the last bit of the selected length has been clocked out, the block pulses `start_o` and presents the channel address to the analog core. The core returns a 12-bit result with `done_i`. The block formats that result and holds it for the next frame.

All pins are sampled with the system clock. Serial-clock and select edges are found by comparing each sample with the one before it.

Top module: `adc_serial_port`

## Requirements
- R1: The control word is received first bit first, as bits 7 down to 0. Bits 7..4 are the channel address, bits 3..2 the length code, bit 1 the order flag and bit 0 the format flag. `chan_o` takes the address in the cycle after the falling edge that ends the data phase, the same cycle in which `start_o` pulses, and it changes at no other time.
- R2: Length code 01 gives 8 bits, code 11 gives 16 bits, and codes 00 and 10 give 12 bits. The code takes effect in the frame that carries it, from its sixth rising edge. `start_o` pulses once, right after the falling serial-clock edge whose count equals that length.
- R3: In 8-bit mode with most significant bit first, the output bits are result bits 11 down to 4. The four low bits are dropped.
- R4: In 16-bit mode the 12 result bits are followed by four zeros.
- R5: Order flag 0 sends the most significant bit first and order flag 1 sends the least significant bit first. The flag applies from the next frame, never to the frame that carries it.
- R6: Format flag 0 gives plain unsigned binary. Format flag 1 gives the unsigned code with its top bit inverted, so mid-scale 0x800 becomes 0x000 and 0x7FF becomes 0xFFF. The flag applies to the conversion started in its frame. The data being sent during that frame is unaffected.
- R7: The result delivered with `done_i` is sent in the next frame. Its first bit appears on `sdo_o` once select goes low, and each later bit appears after a falling serial-clock edge.
- R8: While select is high, `sdo_o` is 0 and the bit counters are cleared. A frame that ends before its final falling edge starts no conversion. A frame with fewer than 8 rising edges leaves the order flag, the format flag and the held result unchanged.
- R9: `start_o` lasts a single cycle, occurs at most once per frame, and only while select is low.
- R10: After reset, `sdo_o` and `start_o` are 0 and `chan_o` is 0. Output length is 12 bits, most significant bit first, unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial control data in |
| result_i | input | 12 | Conversion result from the analog core |
| done_i | input | 1 | One-cycle strobe: result_i valid |
| sdo_o | output | 1 | Serial result data out |
| start_o | output | 1 | One-cycle conversion start pulse |
| chan_o | output | 4 | Channel address for the conversion |

## Verification
The assertions assume that `sclk_i`, `cs_ni` and `sdi_i` change only away from the system clock edge. They also assume that each serial-clock level lasts at least two system clocks, and that select stays low for at least one system clock after the final falling serial edge, so that `start_o` falls inside the frame. The stimulus holds each serial-clock level for four system clocks and keeps select low for four clocks after the last edge. It drives every input on the falling system-clock edge. The core model returns `done_i` a few cycles after `start_o`, well before the next frame begins. No frame in LSB-first order changes the length, so the one result that such a change may corrupt is never checked.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int RES_W  = 12;
  localparam int CTRL_W = 8;
  localparam int ADDR_W = 4;
  localparam int DROP_W = 4;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {LEN_8, LEN_12, LEN_16} len_e;

  function automatic len_e decode_len(logic [1:0] code);
    case (code)
      2'b01:   return LEN_8;
      2'b11:   return LEN_16;
      default: return LEN_12;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] len_bits(len_e len);
    case (len)
      LEN_8:   return CNT_W'(RES_W - DROP_W);
      LEN_16:  return CNT_W'(RES_W + DROP_W);
      default: return CNT_W'(RES_W);
    endcase
  endfunction

  // bit k of the frame's output stream
  function automatic logic pick_bit(logic [RES_W-1:0] w, len_e len, logic lsb,
                                    logic [CNT_W-1:0] k);
    int pos;
    if (k >= len_bits(len)) return 1'b0;
    if (!lsb) begin
      if (int'(k) >= RES_W) return 1'b0;
      return w[RES_W-1-int'(k)];
    end
    pos = int'(k) + ((len == LEN_8) ? DROP_W : 0);
    if (pos >= RES_W) return 1'b0;
    return w[pos];
  endfunction
endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  fcnt_o,
  output len_e              len_o,
  output logic              lsb_nxt_o,
  output logic              lsb_cur_o,
  output logic              fmt_conv_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] chan_o
);
  localparam logic [CNT_W-1:0] LEN_RISE = CNT_W'(6);
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(CTRL_W);

  logic [CTRL_W-1:0] shreg_q;
  logic [CNT_W-1:0]  rcnt_q, fcnt_q, fnext;
  logic              fmt_pend_q, started_q;

  assign fnext  = fcnt_q + 1'b1;
  assign fcnt_o = fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      rcnt_q     <= '0;
      fcnt_q     <= '0;
      len_o      <= LEN_12;
      lsb_nxt_o  <= 1'b0;
      lsb_cur_o  <= 1'b0;
      fmt_pend_q <= 1'b0;
      fmt_conv_o <= 1'b0;
      started_q  <= 1'b0;
      start_o    <= 1'b0;
      chan_o     <= '0;
    end else begin
      start_o <= 1'b0;
      if (!cs_act_i) begin
        shreg_q   <= '0;
        rcnt_q    <= '0;
        fcnt_q    <= '0;
        started_q <= 1'b0;
      end else begin
        if (cs_start_i) lsb_cur_o <= lsb_nxt_o;
        if (rise_i && rcnt_q < WORD_END) begin
          shreg_q <= {shreg_q[CTRL_W-2:0], sdi_i};
          rcnt_q  <= rcnt_q + 1'b1;
          if (rcnt_q + 1'b1 == LEN_RISE) len_o <= decode_len({shreg_q[0], sdi_i});
          if (rcnt_q + 1'b1 == WORD_END) begin
            lsb_nxt_o  <= shreg_q[0];
            fmt_pend_q <= sdi_i;
          end
        end
        if (fall_i) begin
          if (fcnt_q != '1) fcnt_q <= fnext;
          if (!started_q && fnext == len_bits(len_o)) begin
            started_q  <= 1'b1;
            start_o    <= 1'b1;
            chan_o     <= shreg_q[CTRL_W-1 -: ADDR_W];
            fmt_conv_o <= fmt_pend_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_port_out.sv
module adc_port_out
  import adc_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             done_i,
  input  logic             fmt_i,
  input  len_e             len_i,
  input  logic             lsb_i,
  input  logic [CNT_W-1:0] fcnt_i,
  input  logic             cs_act_i,
  input  logic             cs_start_i,
  input  logic             fall_i,
  output logic             sdo_o
);
  logic [RES_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sdo_o  <= 1'b0;
    end else begin
      if (done_i) word_q <= fmt_i ? {~result_i[RES_W-1], result_i[RES_W-2:0]} : result_i;
      if (!cs_act_i)       sdo_o <= 1'b0;
      else if (cs_start_i) sdo_o <= pick_bit(word_q, len_i, lsb_i, '0);
      else if (fall_i)     sdo_o <= pick_bit(word_q, len_i, lsb_i, fcnt_i + 1'b1);
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              done_i,
  output logic              sdo_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] chan_o
);
  logic sclk_q, cs_q;
  logic cs_act, cs_start, rise, fall;
  logic [CNT_W-1:0] fcnt;
  len_e len;
  logic lsb_nxt, lsb_cur, fmt_conv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign cs_act   = !cs_ni;
  assign cs_start = cs_q && !cs_ni;
  assign rise     = sclk_i && !sclk_q;
  assign fall     = !sclk_i && sclk_q;

  adc_port_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_start_i (cs_start),
    .rise_i     (rise),
    .fall_i     (fall),
    .sdi_i      (sdi_i),
    .fcnt_o     (fcnt),
    .len_o      (len),
    .lsb_nxt_o  (lsb_nxt),
    .lsb_cur_o  (lsb_cur),
    .fmt_conv_o (fmt_conv),
    .start_o    (start_o),
    .chan_o     (chan_o)
  );

  adc_port_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .result_i   (result_i),
    .done_i     (done_i),
    .fmt_i      (fmt_conv),
    .len_i      (len),
    .lsb_i      (cs_start ? lsb_nxt : lsb_cur),
    .fcnt_i     (fcnt),
    .cs_act_i   (cs_act),
    .cs_start_i (cs_start),
    .fall_i     (fall),
    .sdo_o      (sdo_o)
  );
endmodule

// File: rtl/adc_port_chk.sv
module adc_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sdo_o,
  input logic       start_o,
  input logic [3:0] chan_o
);
  logic [1:0] starts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          starts_q <= '0;
    else if (cs_ni)                       starts_q <= '0;
    else if (start_o && starts_q != 2'd3) starts_q <= starts_q + 1'b1;
  end

  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !sdo_o);
  assert_start_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_start_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !cs_ni);
  assert_one_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> starts_q == 2'd0);
  assert_chan_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chan_o) |-> start_o);
endmodule

bind adc_serial_port adc_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .sdo_o   (sdo_o),
  .start_o (start_o),
  .chan_o  (chan_o)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [11:0] result = '0;
  logic done = 1'b0;
  logic sdo, start;
  logic [3:0] chan;
  logic [11:0] conv_val = '0;
  int total = 0, bad = 0, starts = 0;
  logic finished = 1'b0;
  logic busy = 1'b0;
  logic [2:0] dly = '0;

  always #10 clk = ~clk;

  adc_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .result_i(result), .done_i(done), .sdo_o(sdo), .start_o(start), .chan_o(chan)
  );

  // analog core model
  always @(posedge clk) begin
    done <= 1'b0;
    if (start) begin
      busy <= 1'b1; dly <= '0; starts <= starts + 1;
    end else if (busy) begin
      dly <= dly + 1'b1;
      if (dly == 3'd3) begin busy <= 1'b0; done <= 1'b1; result <= conv_val; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_seq(logic [11:0] w, int n, logic lsb);
    logic [15:0] s = '0;
    for (int k = 0; k < n; k++) begin
      if (!lsb)        s[k] = (k < 12) ? w[11-k] : 1'b0;
      else if (n == 8) s[k] = w[4+k];
      else             s[k] = (k < 12) ? w[k] : 1'b0;
    end
    return s;
  endfunction

  function automatic logic [15:0] mask(int n);
    return (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
  endfunction

  function automatic logic [7:0] ctrl(logic [3:0] a, logic [1:0] l, logic o, logic f);
    return {a, l, o, f};
  endfunction

  task automatic run_frame(input logic [7:0] c, input int n, output logic [15:0] got);
    got = '0;
    @(negedge clk); cs_n = 1'b0; sdi = c[7];
    repeat (4) @(negedge clk);
    got[0] = sdo;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (i + 1 < 8) sdi = c[6-i];
      repeat (4) @(negedge clk);
      if (i + 1 < 16) got[i+1] = sdo;
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 idle sdo", 32'(sdo), 32'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic frame_chk(input string req, input logic [7:0] c, input int n,
                           input logic [11:0] w, input int olen, input logic lsb);
    logic [15:0] got;
    run_frame(c, n, got);
    chk(req, 32'(got & mask(olen)), 32'(exp_seq(w, olen, lsb) & mask(olen)));
  endtask

  task automatic t_reset;
    chk("R10 sdo", 32'(sdo), 32'd0);
    chk("R10 start", 32'(start), 32'd0);
    chk("R10 chan", 32'(chan), 32'd0);
  endtask

  task automatic t_msb12;
    logic [15:0] g;
    int s0 = starts;
    conv_val = 12'hA5C;
    run_frame(ctrl(4'h5, 2'b00, 1'b0, 1'b0), 12, g);
    chk("R2 start after 12", starts - s0, 1);
    chk("R1 chan", 32'(chan), 32'h5);
    conv_val = 12'h123;
    frame_chk("R7 msb12 result", ctrl(4'h3, 2'b00, 1'b0, 1'b0), 12, 12'hA5C, 12, 1'b0);
    chk("R1 chan second", 32'(chan), 32'h3);
  endtask

  task automatic t_format;
    conv_val = 12'h800;
    frame_chk("R6 current frame unaffected", ctrl(4'h6, 2'b00, 1'b0, 1'b1), 12, 12'h123, 12, 1'b0);
    conv_val = 12'h7FF;
    frame_chk("R6 midscale signed", ctrl(4'h6, 2'b00, 1'b0, 1'b1), 12, 12'h000, 12, 1'b0);
    conv_val = 12'hABC;
    frame_chk("R6 top signed", ctrl(4'h6, 2'b00, 1'b0, 1'b0), 12, 12'hFFF, 12, 1'b0);
  endtask

  task automatic t_len8;
    int s0 = starts;
    conv_val = 12'hF37;
    frame_chk("R3 8-bit truncation", ctrl(4'h2, 2'b01, 1'b0, 1'b0), 8, 12'hABC, 8, 1'b0);
    chk("R2 start after 8", starts - s0, 1);
    chk("R1 chan len8", 32'(chan), 32'h2);
    conv_val = 12'h5A1;
    frame_chk("R2 back to 12", ctrl(4'h2, 2'b10, 1'b0, 1'b0), 12, 12'hF37, 12, 1'b0);
  endtask

  task automatic t_len16;
    int s0 = starts;
    conv_val = 12'h3C6;
    frame_chk("R4 16-bit padding", ctrl(4'h9, 2'b11, 1'b0, 1'b0), 16, 12'h5A1, 16, 1'b0);
    chk("R2 start after 16", starts - s0, 1);
    conv_val = 12'h2B7;
    frame_chk("R4 following frame", ctrl(4'h9, 2'b00, 1'b0, 1'b0), 12, 12'h3C6, 12, 1'b0);
  endtask

  task automatic t_order;
    conv_val = 12'h6D9;
    frame_chk("R5 current frame msb", ctrl(4'h4, 2'b00, 1'b1, 1'b0), 12, 12'h2B7, 12, 1'b0);
    conv_val = 12'hE48;
    frame_chk("R5 lsb first", ctrl(4'h4, 2'b00, 1'b1, 1'b0), 12, 12'h6D9, 12, 1'b1);
    conv_val = 12'h1F0;
    frame_chk("R5 lsb persists one frame", ctrl(4'h4, 2'b00, 1'b0, 1'b0), 12, 12'hE48, 12, 1'b1);
  endtask

  task automatic t_abort;
    logic [15:0] g;
    int s0 = starts;
    conv_val = 12'h999;
    run_frame(ctrl(4'h7, 2'b00, 1'b1, 1'b1), 5, g);
    chk("R8 no start on short frame", starts - s0, 0);
    chk("R8 chan held", 32'(chan), 32'h4);
    conv_val = 12'h444;
    frame_chk("R8 state kept", ctrl(4'h1, 2'b00, 1'b0, 1'b0), 12, 12'h1F0, 12, 1'b0);
    chk("R9 one start per frame", starts - s0, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_msb12();
    t_format();
    t_len8();
    t_len16();
    t_order();
    t_abort();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule